// File: doc/BRIEF.md
# Virtual-Channel Output Port with Packet Ownership

This block is one output port of a five-input mesh router. The crossbar delivers flits to it on one write channel per output virtual channel. Each channel has a small FIFO. The port sends at most one buffered flit per cycle on a single outgoing link, which leads to a neighbouring router or to the local processing element. A flit is 8 data bits plus a 2-bit kind: idle, start, body or end. The link adds one bit that names the channel the flit travels on.

Each virtual channel holds an ownership register. A free channel is taken by the first start flit written to it, and it records which of the five inputs sent that flit. From then on the channel accepts only body and end flits from that input. Writing the end flit makes the channel free again. Because of this, two packets can share the link, their flits alternating, without mixing inside either channel.

The link is shared among the channels that have data and whose downstream buffer reports room. The share is round-robin. A packet that is stalled downstream in one channel therefore does not block a packet in the other channel. The crossbar uses the busy and owner outputs to steer packets to a channel.

Top module: `vc_out_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every channel is free (`vc_busy` = 0) and the link carries the idle kind.
- R2: A free channel accepts only a start flit (kind code 1). Idle (0), body (2) and end (3) written to a free channel are refused (`wr_accept` = 0) and never appear on the link.
- R3: An accepted start flit on a free channel sets that channel busy from the next cycle. The channel's `vc_owner` field then shows the writer's input index.
- R4: A busy channel accepts only body or end flits whose input index equals its recorded owner. Flits from any other input, and a second start flit, are refused.
- R5: Accepting an end flit frees the channel from the next cycle, so a new start flit is accepted in that cycle.
- R6: Each channel stores at most DEPTH (4) flits. A write to a channel that holds four unsent flits is refused.
- R7: Flits of one channel leave in the order they were written, with their data, kind and channel number on the link. When the link is free and the downstream has room, a flit accepted at clock edge n appears on the link after edge n+1.
- R8: A channel sends a flit only when it held data and its `ds_ready` bit was high before the sending edge. A channel stalled in this way does not hold back the other channel.
- R9: When both channels may send, the link alternates between them on successive cycles.
- R10: In a cycle where no channel may send, the link carries the idle kind, zero data and channel number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | NUM_VC | Per-channel write strobe from the crossbar |
| wr_src | input | NUM_VC*3 | Per-channel input index of the writer (0..4) |
| wr_type | input | NUM_VC*2 | Per-channel flit kind: 0 idle, 1 start, 2 body, 3 end |
| wr_data | input | NUM_VC*DATA_W | Per-channel flit data |
| wr_accept | output | NUM_VC | Per-channel: the write in this cycle is taken |
| vc_busy | output | NUM_VC | Per-channel: owned by a packet in progress |
| vc_owner | output | NUM_VC*3 | Per-channel recorded owner input index |
| ds_ready | input | NUM_VC | Per-channel downstream buffer has room |
| link_data | output | DATA_W | Outgoing flit data |
| link_type | output | 2 | Outgoing flit kind |
| link_vc | output | 1 | Channel the outgoing flit belongs to |

## Verification
The hardest state to reach is a channel that is full and stalled downstream while the other channel carries a complete packet past it. To reach it, the bench holds one `ds_ready` bit low, fills that channel to its limit, then runs a second packet on the other channel. It checks that only the second packet's flits reach the link, and after that the release delivers the four held flits in order. Alternation is shown by loading both channels while both ready bits are low and then raising the two bits in the same cycle. This gives the arbiter a known tie to resolve.

// File: rtl/vc_out_port.sv
module vc_out_port #(
  parameter int DATA_W = 8,
  parameter int NUM_VC = 2,
  parameter int DEPTH  = 4,
  parameter int NUM_IN = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_VC-1:0]                  wr_valid,
  input  logic [NUM_VC*$clog2(NUM_IN)-1:0]   wr_src,
  input  logic [NUM_VC*2-1:0]                wr_type,
  input  logic [NUM_VC*DATA_W-1:0]           wr_data,
  output logic [NUM_VC-1:0]                  wr_accept,
  output logic [NUM_VC-1:0]                  vc_busy,
  output logic [NUM_VC*$clog2(NUM_IN)-1:0]   vc_owner,
  input  logic [NUM_VC-1:0]                  ds_ready,
  output logic [DATA_W-1:0]                  link_data,
  output logic [1:0]                         link_type,
  output logic [$clog2(NUM_VC)-1:0]          link_vc
);
  localparam int SW = $clog2(NUM_IN);
  localparam int VW = $clog2(NUM_VC);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = DATA_W + 2;
  localparam logic [1:0] K_IDLE = 2'd0, K_START = 2'd1, K_BODY = 2'd2, K_END = 2'd3;

  logic [NUM_VC-1:0] nonempty, pop;
  logic [FW-1:0]     head [NUM_VC];

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [FW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [SW-1:0] own;
    logic          busy;
    wire  [1:0]    kind = wr_type[v*2 +: 2];
    wire  [SW-1:0] src  = wr_src[v*SW +: SW];
    wire           room = cnt != CW'(DEPTH);
    wire           ok   = busy ? (src == own && (kind == K_BODY || kind == K_END))
                               : (kind == K_START);
    wire           push = wr_valid[v] && room && ok;

    assign wr_accept[v]          = push;
    assign vc_busy[v]            = busy;
    assign vc_owner[v*SW +: SW]  = own;
    assign nonempty[v]           = cnt != '0;
    assign head[v]               = mem[rp];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0; busy <= 1'b0; own <= '0;
      end else begin
        if (push) begin
          mem[wp] <= {kind, wr_data[v*DATA_W +: DATA_W]};
          wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
          if (kind == K_START) begin busy <= 1'b1; own <= src; end
          if (kind == K_END)   busy <= 1'b0;
        end
        if (pop[v]) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop[v]);
      end
    end
  end

  wire [NUM_VC-1:0] elig = nonempty & ds_ready;
  logic [VW-1:0] last, pick;
  logic          found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= NUM_VC; k++) begin
      int idx;
      idx = (int'(last) + k) % NUM_VC;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = VW'(idx);
      end
    end
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_pop
    assign pop[v] = found && (pick == VW'(v));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_data <= '0; link_type <= K_IDLE; link_vc <= '0; last <= VW'(NUM_VC - 1);
    end else if (found) begin
      {link_type, link_data} <= head[pick];
      link_vc <= pick;
      last    <= pick;
    end else begin
      link_data <= '0; link_type <= K_IDLE; link_vc <= '0;
    end
  end
endmodule

module vc_out_port_chk #(
  parameter int DATA_W = 8,
  parameter int NUM_VC = 2,
  parameter int NUM_IN = 5
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_VC-1:0]                wr_valid,
  input logic [NUM_VC*$clog2(NUM_IN)-1:0] wr_src,
  input logic [NUM_VC*2-1:0]              wr_type,
  input logic [NUM_VC-1:0]                wr_accept,
  input logic [NUM_VC-1:0]                vc_busy,
  input logic [NUM_VC*$clog2(NUM_IN)-1:0] vc_owner,
  input logic [NUM_VC-1:0]                ds_ready,
  input logic [DATA_W-1:0]                link_data,
  input logic [1:0]                       link_type,
  input logic [$clog2(NUM_VC)-1:0]        link_vc
);
  localparam int SW = $clog2(NUM_IN);
  logic [NUM_VC-1:0] rdy_q;
  always_ff @(posedge clk) rdy_q <= rst_n ? ds_ready : '0;

  a_r8_send_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    link_type != 2'd0 |-> rdy_q[link_vc]);
  a_r10_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
    link_type == 2'd0 |-> (link_data == '0 && link_vc == '0));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_a
    a_r2_free_start_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid[v] && !vc_busy[v] && wr_type[v*2 +: 2] != 2'd1) |-> !wr_accept[v]);
    a_r3_claim: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept[v] && !vc_busy[v]) |=>
        (vc_busy[v] && vc_owner[v*SW +: SW] == $past(wr_src[v*SW +: SW])));
    a_r4_foreign_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (vc_busy[v] && wr_src[v*SW +: SW] != vc_owner[v*SW +: SW]) |-> !wr_accept[v]);
    a_r5_end_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept[v] && wr_type[v*2 +: 2] == 2'd3) |=> !vc_busy[v]);
  end
endmodule

bind vc_out_port vc_out_port_chk #(.DATA_W(DATA_W), .NUM_VC(NUM_VC), .NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_src(wr_src), .wr_type(wr_type),
  .wr_accept(wr_accept), .vc_busy(vc_busy), .vc_owner(vc_owner), .ds_ready(ds_ready),
  .link_data(link_data), .link_type(link_type), .link_vc(link_vc));

// File: tb/tb_vc_out_port.sv
module tb_vc_out_port;
  logic       clk = 0, rst_n = 0;
  logic [1:0] wr_valid = 0, wr_accept, vc_busy, ds_ready = 2'b11;
  logic [5:0] wr_src = 0, vc_owner;
  logic [3:0] wr_type = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] link_data;
  logic [1:0] link_type;
  logic [0:0] link_vc;

  vc_out_port dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, log_n = 0;
  logic [7:0] l_data [64];
  logic [1:0] l_type [64];
  logic       l_vc   [64];
  int         l_cyc  [64];
  bit         done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && link_type != 0 && log_n < 64) begin
    l_data[log_n] = link_data; l_type[log_n] = link_type;
    l_vc[log_n] = link_vc; l_cyc[log_n] = cyc; log_n = log_n + 1;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(int vc, int src, int kind, int data, bit exp_acc, string tag);
    @(negedge clk);
    wr_valid = 0;
    wr_valid[vc] = 1; wr_src[vc*3 +: 3] = 3'(src);
    wr_type[vc*2 +: 2] = 2'(kind); wr_data[vc*8 +: 8] = 8'(data);
    #1 check(wr_accept[vc] == exp_acc, tag, wr_accept[vc], exp_acc);
  endtask

  task automatic quiet(int n);
    @(negedge clk); wr_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_flit(int idx, int vc, int kind, int data, string tag);
    check(idx < log_n && l_vc[idx] == vc && l_type[idx] == kind && l_data[idx] == data,
          tag, {l_vc[idx], l_type[idx], l_data[idx]}, {vc[0], kind[1:0], data[7:0]});
  endtask

  task automatic t_reset;
    check(vc_busy == 0, "R1 busy after reset", vc_busy, 0);
    check(link_type == 0, "R1 link idle after reset", link_type, 0);
    check(link_data == 0 && link_vc == 0, "R10 idle fields zero", {link_vc, link_data}, 0);
  endtask

  task automatic t_basic;
    int base, c0;
    base = log_n;
    put(0, 2, 1, 'hAA, 1, "R3 start accepted");
    c0 = cyc;
    put(0, 2, 2, 'h11, 1, "R4 owner body accepted");
    check(vc_busy[0] && vc_owner[2:0] == 2, "R3 claimed by input 2", {vc_busy[0], vc_owner[2:0]}, 'h12);
    put(0, 2, 3, 'h22, 1, "R4 owner end accepted");
    quiet(1);
    check(vc_busy[0] == 0, "R5 end frees channel", vc_busy[0], 0);
    quiet(4);
    expect_flit(base, 0, 1, 'hAA, "R7 first flit");
    expect_flit(base + 1, 0, 2, 'h11, "R7 second flit");
    expect_flit(base + 2, 0, 3, 'h22, "R7 third flit");
    check(l_cyc[base] == c0 + 2, "R7 two-edge latency", l_cyc[base], c0 + 2);
  endtask

  task automatic t_reject;
    int base;
    base = log_n;
    put(1, 0, 2, 'h33, 0, "R2 body on free refused");
    put(1, 0, 3, 'h34, 0, "R2 end on free refused");
    put(1, 0, 0, 'h35, 0, "R2 idle on free refused");
    quiet(3);
    check(log_n == base && vc_busy[1] == 0, "R2 nothing sent, still free", log_n - base, 0);
    put(1, 1, 1, 'h40, 1, "R3 start vc1");
    put(1, 4, 2, 'h41, 0, "R4 foreign body refused");
    put(1, 1, 1, 'h42, 0, "R4 second start refused");
    put(1, 1, 3, 'h43, 1, "R4 owner end accepted");
    put(1, 3, 1, 'h44, 1, "R5 reclaim next cycle");
    put(1, 3, 3, 'h45, 1, "R5 end of second packet");
    quiet(4);
    check(log_n == base + 4, "R4 only accepted flits sent", log_n - base, 4);
    expect_flit(base + 1, 1, 3, 'h43, "R7 vc1 end flit");
    expect_flit(base + 2, 1, 1, 'h44, "R7 vc1 next start");
  endtask

  task automatic t_full_bypass;
    int base;
    base = log_n;
    @(negedge clk) ds_ready = 2'b10;
    put(0, 0, 1, 'h50, 1, "R6 fill 1");
    put(0, 0, 2, 'h51, 1, "R6 fill 2");
    put(0, 0, 2, 'h52, 1, "R6 fill 3");
    put(0, 0, 2, 'h53, 1, "R6 fill 4");
    put(0, 0, 2, 'h54, 0, "R6 fifth refused");
    put(1, 3, 1, 'h60, 1, "R8 bypass start");
    put(1, 3, 3, 'h61, 1, "R8 bypass end");
    quiet(4);
    check(log_n == base + 2, "R8 stalled vc silent", log_n - base, 2);
    expect_flit(base, 1, 1, 'h60, "R8 bypass flit first");
    check(link_type == 0 && link_data == 0, "R10 idle while stalled", link_type, 0);
    ds_ready = 2'b11;
    quiet(6);
    check(log_n == base + 6, "R6 four held flits sent", log_n - base, 6);
    expect_flit(base + 2, 0, 1, 'h50, "R7 held flit 0");
    expect_flit(base + 5, 0, 2, 'h53, "R7 held flit 3");
    put(0, 0, 3, 'h55, 1, "R5 close stalled packet");
    quiet(4);
  endtask

  task automatic t_rr;
    int base;
    base = log_n;
    @(negedge clk) ds_ready = 2'b00;
    put(0, 0, 1, 'h70, 1, "R9 load vc0 a");
    put(1, 4, 1, 'h80, 1, "R9 load vc1 a");
    put(0, 0, 3, 'h71, 1, "R9 load vc0 b");
    put(1, 4, 3, 'h81, 1, "R9 load vc1 b");
    quiet(2);
    check(log_n == base, "R8 nothing sent without room", log_n - base, 0);
    ds_ready = 2'b11;
    quiet(6);
    check(log_n == base + 4, "R9 four flits", log_n - base, 4);
    for (int k = 0; k < 3; k++) begin
      check(l_vc[base+k] != l_vc[base+k+1], "R9 alternation", l_vc[base+k+1], !l_vc[base+k]);
      check(l_cyc[base+k+1] == l_cyc[base+k] + 1, "R9 back-to-back", l_cyc[base+k+1], l_cyc[base+k] + 1);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset;
    @(negedge clk) rst_n = 1;
    #1 check(vc_busy == 0 && link_type == 0, "R1 first cycle after reset", {vc_busy, link_type}, 0);
    t_basic;
    t_reject;
    t_full_bypass;
    t_rr;
    done = 1;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run;
    end
  end
endmodule